// File: doc/BRIEF.md
# CPU Input Pin Event Decoder

This block sits between a set of level-type control pins arriving at a processor core and the core's internal request logic. It samples a pin vector each clock, remembers the last sampled level of every defined pin, and acts only in a cycle where a pin's level has changed. Each pin carries its own rule. The two interrupt pins and the soft-reset pin make their pending requests follow the level. The machine-check pin raises a request only when it falls. The checkstop pin latches a halt that only reset removes. The hard-reset pin yields a single-cycle request to leave the current execution context. The time-base enable pin gates a run flag for the time base.

Pending requests are sticky. A per-bit acknowledge input lets the consumer clear a request while the pin is still held. The request then stays clear until the pin produces a fresh qualifying transition. Prioritising the requests, vectoring exceptions and the time base counter itself all live outside this block.

Pin positions in `pins_i`: bit 0 external interrupt, bit 1 management interrupt, bit 2 machine check, bit 3 checkstop, bit 4 hard reset, bit 5 soft reset, bit 6 time-base enable. Any higher bit is undefined. Positions in `pend_o` and `ack_i`: bit 0 external interrupt, bit 1 management interrupt, bit 2 machine check, bit 3 soft reset. All pins are active high.

Top module: `pin_event_decoder`

## Requirements
- R1: A pin level sampled equal to the previously stored level of that pin produces no event; outputs change only through acknowledge or a level change.
- R2: A rising external (bit 0) or management (bit 1) pin sets `pend_o` bit 0 or bit 1 one clock after it is sampled, and a falling one clears it one clock after.
- R3: An `ack_i` bit clears the matching pending bit one clock later even if the pin is still high. A set event on the same bit in the same cycle wins over the acknowledge.
- R4: The machine-check pin (bit 2) sets `pend_o` bit 2 one clock after it is sampled going 1 to 0. Its rising transition changes nothing.
- R5: A rising checkstop pin (bit 3) sets `halt_o` one clock later. Neither the pin falling nor any later pin activity clears it; only reset does.
- R6: A rising hard-reset pin (bit 4) drives `exit_req_o` high for exactly one clock, one clock after the rise is sampled.
- R7: The soft-reset pin (bit 5) sets `pend_o` bit 3 on its rise and clears it on its fall, each one clock after sampling.
- R8: `tb_run_o` goes high one clock after the time-base enable pin (bit 6) is sampled rising, and low one clock after it is sampled falling.
- R9: Pin bits above bit 6 are ignored: toggling them changes no output and no stored level.
- R10: While reset is asserted, every output and the stored pin levels are zero, whatever the pins show.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PINS | Sampled processor control pin levels |
| ack_i | input | 4 | Per-bit clear of pending requests |
| pend_o | output | 4 | Sticky pending requests (ext, mgmt, mcheck, soft reset) |
| halt_o | output | 1 | Checkstop halt, cleared only by reset |
| exit_req_o | output | 1 | One-cycle request to leave the execution context |
| tb_run_o | output | 1 | Time-base run enable |

## Verification
The pins are driven one at a time through rise, hold and fall. This separates edge-triggered rules from level-following ones: a held high level must not re-raise an acknowledged request, and machine check must react to the fall but not the rise. Simultaneous changes on several pins, an acknowledge colliding with a set event, and repeated checkstop pulses show that each pin's rule acts on its own and that the halt is truly latched. Toggling the undefined bit, and applying reset while every pin is high, show that nothing leaks from outside the defined set and that reset wins over pin activity.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

    // Pin positions within the sampled vector
    localparam int PIN_EXT   = 0;
    localparam int PIN_MGMT  = 1;
    localparam int PIN_MCHK  = 2;
    localparam int PIN_CSTOP = 3;
    localparam int PIN_HRST  = 4;
    localparam int PIN_SRST  = 5;
    localparam int PIN_TBEN  = 6;
    localparam int NUM_DEFINED = 7;

    // Pending request positions
    localparam int REQ_EXT  = 0;
    localparam int REQ_MGMT = 1;
    localparam int REQ_MCHK = 2;
    localparam int REQ_SRST = 3;
    localparam int NUM_REQ  = 4;

    typedef enum logic {
        MODE_FOLLOW   = 1'b0,
        MODE_FALL_SET = 1'b1
    } req_mode_e;

    typedef struct packed {
        logic halt;
        logic exit_req;
        logic tb_run;
    } core_ctl_t;

    function automatic int req_src_pin(input int r);
        case (r)
            REQ_EXT:  return PIN_EXT;
            REQ_MGMT: return PIN_MGMT;
            REQ_MCHK: return PIN_MCHK;
            default:  return PIN_SRST;
        endcase
    endfunction

    function automatic req_mode_e req_mode(input int r);
        return (r == REQ_MCHK) ? MODE_FALL_SET : MODE_FOLLOW;
    endfunction

endpackage

// File: rtl/pin_level_tracker.sv
module pin_level_tracker #(
    parameter int NUM_PINS    = 8,
    parameter int NUM_DEFINED = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins_i,
    output logic [NUM_PINS-1:0] rise_o,
    output logic [NUM_PINS-1:0] fall_o
);

    function automatic logic [NUM_PINS-1:0] defined_mask();
        logic [NUM_PINS-1:0] m;
        for (int i = 0; i < NUM_PINS; i++) m[i] = (i < NUM_DEFINED);
        return m;
    endfunction

    localparam logic [NUM_PINS-1:0] DEF_MASK = defined_mask();

    logic [NUM_PINS-1:0] level_d, level_q;

    always_comb begin
        // Undefined positions keep their stored value (zero from reset)
        level_d = (pins_i & DEF_MASK) | (level_q & ~DEF_MASK);
        rise_o  =  pins_i & ~level_q & DEF_MASK;
        fall_o  = ~pins_i &  level_q & DEF_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= level_d;
    end

endmodule

// File: rtl/req_sticky_bit.sv
module req_sticky_bit
    import pin_evt_pkg::*;
#(
    parameter req_mode_e MODE = MODE_FOLLOW
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic fall_i,
    input  logic ack_i,
    output logic req_o
);

    logic req_d, req_q;

    generate
        if (MODE == MODE_FALL_SET) begin : g_fall_set
            always_comb begin
                req_d = req_q;
                if (fall_i)     req_d = 1'b1;
                else if (ack_i) req_d = 1'b0;
            end
            logic unused_rise;
            assign unused_rise = rise_i;
        end else begin : g_follow
            always_comb begin
                req_d = req_q;
                if (rise_i)      req_d = 1'b1;
                else if (fall_i) req_d = 1'b0;
                else if (ack_i)  req_d = 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_d;
    end

    assign req_o = req_q;

endmodule

// File: rtl/pin_event_decoder.sv
module pin_event_decoder
    import pin_evt_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic [NUM_REQ-1:0]  ack_i,
    output logic [NUM_REQ-1:0]  pend_o,
    output logic                halt_o,
    output logic                exit_req_o,
    output logic                tb_run_o
);

    logic [NUM_PINS-1:0] rise_w, fall_w;
    core_ctl_t ctl_d, ctl_q;

    pin_level_tracker #(
        .NUM_PINS    (NUM_PINS),
        .NUM_DEFINED (NUM_DEFINED)
    ) u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins_i),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    generate
        for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
            localparam int SRC = req_src_pin(r);
            req_sticky_bit #(
                .MODE (req_mode(r))
            ) u_bit (
                .clk    (clk),
                .rst_n  (rst_n),
                .rise_i (rise_w[SRC]),
                .fall_i (fall_w[SRC]),
                .ack_i  (ack_i[r]),
                .req_o  (pend_o[r])
            );
        end
    endgenerate

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.exit_req = rise_w[PIN_HRST];
        if (rise_w[PIN_CSTOP]) ctl_d.halt   = 1'b1;
        if (rise_w[PIN_TBEN])  ctl_d.tb_run = 1'b1;
        else if (fall_w[PIN_TBEN]) ctl_d.tb_run = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign halt_o     = ctl_q.halt;
    assign exit_req_o = ctl_q.exit_req;
    assign tb_run_o   = ctl_q.tb_run;

endmodule

// File: rtl/pin_event_decoder_chk.sv
module pin_event_decoder_chk
    import pin_evt_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_REQ-1:0]  ack_i,
    input logic [NUM_REQ-1:0]  pend_o,
    input logic                halt_o,
    input logic                exit_req_o,
    input logic                tb_run_o,
    input logic [NUM_PINS-1:0] rise_w,
    input logic [NUM_PINS-1:0] fall_w
);

    a_r1_quiet_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_w == '0 && fall_w == '0 && ack_i == '0)
        |=> ($stable(pend_o) && $stable(tb_run_o) && !exit_req_o));

    a_r2_ext_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        rise_w[PIN_EXT] |=> pend_o[REQ_EXT]);

    a_r2_mgmt_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
        fall_w[PIN_MGMT] |=> !pend_o[REQ_MGMT]);

    a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i[REQ_EXT] && !rise_w[PIN_EXT]) |=> !pend_o[REQ_EXT]);

    a_r4_mchk_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
        fall_w[PIN_MCHK] |=> pend_o[REQ_MCHK]);

    a_r4_mchk_rise_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_w[PIN_MCHK] && !pend_o[REQ_MCHK]) |=> !pend_o[REQ_MCHK]);

    a_r5_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> halt_o);

    a_r6_exit_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req_o |=> !exit_req_o);

    a_r7_srst_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        rise_w[PIN_SRST] |=> pend_o[REQ_SRST]);

    a_r8_tb_follows: assert property (@(posedge clk) disable iff (!rst_n)
        fall_w[PIN_TBEN] |=> !tb_run_o);

endmodule

bind pin_event_decoder pin_event_decoder_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_i      (ack_i),
    .pend_o     (pend_o),
    .halt_o     (halt_o),
    .exit_req_o (exit_req_o),
    .tb_run_o   (tb_run_o),
    .rise_w     (rise_w),
    .fall_w     (fall_w)
);

// File: tb/pin_event_decoder_tb.sv
module pin_event_decoder_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pins = '0;
    logic [3:0] ack = '0;
    logic [3:0] pend;
    logic       halt, exit_req, tb_run;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pin_event_decoder #(.NUM_PINS(8)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins_i     (pins),
        .ack_i      (ack),
        .pend_o     (pend),
        .halt_o     (halt),
        .exit_req_o (exit_req),
        .tb_run_o   (tb_run)
    );

    // {pins, ack, pend, halt, exit, tb, req}
    localparam int NV = 30;
    localparam logic [22:0] VEC [NV] = '{
        {8'h01, 4'h0, 4'h1, 3'b000, 4'd2},  // R2 ext rise
        {8'h01, 4'h0, 4'h1, 3'b000, 4'd1},  // R1 held
        {8'h01, 4'h1, 4'h0, 3'b000, 4'd3},  // R3 ack while high
        {8'h01, 4'h0, 4'h0, 3'b000, 4'd1},  // R1 no re-raise
        {8'h00, 4'h0, 4'h0, 3'b000, 4'd2},
        {8'h02, 4'h0, 4'h2, 3'b000, 4'd2},  // R2 mgmt rise
        {8'h00, 4'h0, 4'h0, 3'b000, 4'd2},  // R2 mgmt fall
        {8'h04, 4'h0, 4'h0, 3'b000, 4'd4},  // R4 rise ignored
        {8'h00, 4'h0, 4'h4, 3'b000, 4'd4},  // R4 fall sets
        {8'h00, 4'h4, 4'h0, 3'b000, 4'd3},  // R3 ack mcheck
        {8'h20, 4'h0, 4'h8, 3'b000, 4'd7},  // R7 soft reset rise
        {8'h00, 4'h0, 4'h0, 3'b000, 4'd7},  // R7 fall
        {8'h40, 4'h0, 4'h0, 3'b001, 4'd8},  // R8 start
        {8'h40, 4'h0, 4'h0, 3'b001, 4'd8},
        {8'h00, 4'h0, 4'h0, 3'b000, 4'd8},  // R8 stop
        {8'h10, 4'h0, 4'h0, 3'b010, 4'd6},  // R6 pulse
        {8'h10, 4'h0, 4'h0, 3'b000, 4'd6},  // R6 single cycle
        {8'h00, 4'h0, 4'h0, 3'b000, 4'd6},
        {8'h80, 4'h0, 4'h0, 3'b000, 4'd9},  // R9 undefined bit
        {8'h00, 4'h0, 4'h0, 3'b000, 4'd9},
        {8'h01, 4'h1, 4'h1, 3'b000, 4'd3},  // R3 set beats ack
        {8'h00, 4'h0, 4'h0, 3'b000, 4'd2},
        {8'h43, 4'h0, 4'h3, 3'b001, 4'd2},  // R2 several pins at once
        {8'h00, 4'h0, 4'h0, 3'b000, 4'd2},
        {8'h08, 4'h0, 4'h0, 3'b100, 4'd5},  // R5 checkstop
        {8'h00, 4'h0, 4'h0, 3'b100, 4'd5},  // R5 fall keeps halt
        {8'h08, 4'h0, 4'h0, 3'b100, 4'd5},
        {8'h24, 4'h0, 4'h8, 3'b100, 4'd7},  // R7 with mcheck rise
        {8'h20, 4'h0, 4'hC, 3'b100, 4'd4},  // R4 fall while srst held
        {8'h00, 4'hC, 4'h0, 3'b100, 4'd3}   // R3 ack plus srst fall
    };

    task automatic check(input int req, input logic [3:0] ep,
                         input logic eh, input logic ee, input logic et);
        n_run++;
        if (pend !== ep || halt !== eh || exit_req !== ee || tb_run !== et) begin
            n_fail++;
            $display("FAIL R%0d: got pend=%h halt=%b exit=%b tb=%b, expected pend=%h halt=%b exit=%b tb=%b",
                     req, pend, halt, exit_req, tb_run, ep, eh, ee, et);
        end
    endtask

    task automatic step(input logic [7:0] p, input logic [3:0] a);
        pins = p;
        ack  = a;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R10: reset state with pins high
        pins = 8'hFF;
        repeat (3) @(posedge clk);
        #1;
        check(10, 4'h0, 1'b0, 1'b0, 1'b0);
        pins = 8'h00;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        step(8'h00, 4'h0);
        check(10, 4'h0, 1'b0, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            logic [22:0] v;
            v = VEC[i];
            step(v[22:15], v[14:11]);
            check(int'(v[3:0]), v[10:7], v[6], v[5], v[4]);
        end

        // R5 / R10: only reset removes the halt
        pins  = 8'hFF;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check(5, 4'h0, 1'b0, 1'b0, 1'b0);
        pins = 8'h00;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        step(8'h00, 4'h0);
        check(10, 4'h0, 1'b0, 1'b0, 1'b0);

        // R9: undefined bit toggled around a held interrupt
        step(8'h01, 4'h0);
        check(2, 4'h1, 1'b0, 1'b0, 1'b0);
        step(8'h81, 4'h0);
        check(9, 4'h1, 1'b0, 1'b0, 1'b0);
        step(8'h01, 4'h0);
        check(9, 4'h1, 1'b0, 1'b0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule